// File: doc/BRIEF.md
# Byte-to-Nibble Double-Edge Ethernet Bridge

This block sits between a MAC-side byte interface and a reduced-pin PHY interface. The byte side moves 8 bits per clock at single data rate. The PHY side moves 4 bits per clock edge, so it uses both edges of the clock. The transmit direction splits each byte into two nibbles. It also folds the frame-enable and error flags onto one control wire: the enable goes out while the clock is high and the error goes out while the clock is low. The receive direction samples the 4-bit bus and the control wire on both edges of the PHY-supplied receive clock. It then rebuilds the byte, the valid flag and the error flag.

A speed input chooses gigabit operation or the 10/100 mode. In gigabit mode every clock carries a full byte. In the 10/100 modes every clock carries one nibble, with the same value on both edges, and a byte takes two clocks with the low nibble first. The transmit byte stream is a valid/ready interface: `gmii_tx_en` is the valid and `gmii_tx_rdy` is the ready. A byte is taken only on a rising clock edge where both are high. While ready is low, the source must hold the byte, the enable and the error flag steady. The receive stream has no back-pressure. `gmii_rx_dv` is a one-cycle valid strobe that the consumer must take when it appears.

Both edges are modelled with ordinary edge-triggered registers and a clock-selected output multiplexer. Clock-to-data skew is added outside the block, and the PHY is not part of it.

Top module: `gmii_rgmii_bridge`

## Requirements
- R1: After reset the transmit data bus and transmit control wire are low, the rebuilt receive byte, valid and error outputs are low, and `gmii_tx_rdy` is high in gigabit mode.
- R2: In gigabit mode, a byte taken at a rising edge appears during the clock cycle that edge starts. Bits [3:0] are on `rgmii_txd` while `rgmii_txc` is high, and bits [7:4] are on it while `rgmii_txc` is low.
- R3: In gigabit mode, during the cycle of a taken byte `rgmii_tx_ctl` is 1 while the clock is high and equals `gmii_tx_er` while the clock is low.
- R4: When no byte is being sent (`gmii_tx_en` low with ready high), `rgmii_txd` and `rgmii_tx_ctl` are low on both clock phases, whatever `gmii_txd` and `gmii_tx_er` hold.
- R5: Speed codes are 2'b00 for 10 Mbps, 2'b01 for 100 Mbps, and 2'b10 or 2'b11 for gigabit. In gigabit mode `gmii_tx_rdy` stays high every cycle.
- R6: In 10/100 mode a taken byte occupies two cycles, low nibble first. Each nibble is on both phases of its cycle. The control wire is 1 while the clock is high and equals the byte's error flag while the clock is low, in both cycles.
- R7: In 10/100 mode `gmii_tx_rdy` is low during the second cycle of a byte. A byte held during that cycle is not taken until the following edge, where its low nibble starts.
- R8: In gigabit mode the rising-edge nibble and control bit plus the following falling-edge nibble and control bit appear together after the next rising edge: `gmii_rxd` = {falling nibble, rising nibble}, `gmii_rx_dv` = rising control bit, and `gmii_rx_er` = falling control bit.
- R9: In 10/100 mode two consecutive receive cycles whose rising-edge control bit is 1 form one byte, with the first nibble as bits [3:0]. `gmii_rx_dv` is high for exactly one cycle, after the rising edge that follows the second nibble. `gmii_rx_er` is the OR of the two falling-edge control bits.
- R10: In 10/100 mode, if the control bit is low in the slot that would complete a byte, the pending nibble is dropped with no valid strobe, and the next control-high slot starts a new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit reference clock (125, 25 or 2.5 MHz) |
| rst_n | input | 1 | Active-low asynchronous reset for both directions |
| speed | input | 2 | Speed select: 00 = 10M, 01 = 100M, 1x = 1000M |
| gmii_txd | input | 8 | Transmit byte |
| gmii_tx_en | input | 1 | Transmit enable, used as the stream valid |
| gmii_tx_er | input | 1 | Transmit error flag of the byte |
| gmii_tx_rdy | output | 1 | Byte accepted at the next edge when high |
| rgmii_txc | output | 1 | Forwarded transmit clock |
| rgmii_txd | output | 4 | Double-edge transmit nibble bus |
| rgmii_tx_ctl | output | 1 | Enable (clock high) / error (clock low) wire |
| rgmii_rxc | input | 1 | Receive clock from the PHY |
| rgmii_rxd | input | 4 | Double-edge receive nibble bus |
| rgmii_rx_ctl | input | 1 | Valid (rising) / error (falling) wire |
| gmii_rxd | output | 8 | Rebuilt receive byte |
| gmii_rx_dv | output | 1 | Receive byte valid strobe |
| gmii_rx_er | output | 1 | Receive error flag |

## Verification
The hardest receive state to reach is a 10/100 byte cut short after its first nibble, because the assembler keeps a half-byte that the ports never show. The bench reaches it by driving one control-high slot and then one control-low slot, followed by two good slots. A bridge that does not drop the orphan nibble then pairs the wrong nibbles. On transmit, the held-while-not-ready case is reached by offering the next byte right after the first one is taken, so it sits through the cycle where ready is low.

// File: rtl/gr_pkg.sv
`timescale 1ns/1ps
package gr_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;
  localparam int LANE_W = NIB_W + 1;

  typedef enum logic [1:0] {
    SPD_10   = 2'b00,
    SPD_100  = 2'b01,
    SPD_1000 = 2'b10
  } speed_e;

  function automatic logic is_gig(input logic [1:0] spd);
    return spd[1];
  endfunction
endpackage

// File: rtl/gr_ddr_out.sv
`timescale 1ns/1ps
module gr_ddr_out #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_rise,
  input  logic [W-1:0] d_fall,
  output logic [W-1:0] q,
  output logic [W-1:0] rise_q,
  output logic [W-1:0] fall_pend
);
  logic [W-1:0] r_q, p_q, f_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q <= '0;
      p_q <= '0;
    end else begin
      r_q <= d_rise;
      p_q <= d_fall;
    end
  end

  // falling half is re-timed onto the low phase of the same cycle
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) f_q <= '0;
    else        f_q <= p_q;
  end

  assign q         = clk ? r_q : f_q;
  assign rise_q    = r_q;
  assign fall_pend = p_q;
endmodule

// File: rtl/gr_ddr_in.sv
`timescale 1ns/1ps
module gr_ddr_in #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_rise,
  output logic [W-1:0] q_fall
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_rise <= '0;
    else        q_rise <= d;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q_fall <= '0;
    else        q_fall <= d;
  end
endmodule

// File: rtl/gr_tx_path.sv
`timescale 1ns/1ps
module gr_tx_path
  import gr_pkg::*;
#(
  parameter int NW = NIB_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    speed,
  input  logic [2*NW-1:0] txd,
  input  logic          tx_en,
  input  logic          tx_er,
  output logic          tx_rdy,
  output logic [NW-1:0] out_nib,
  output logic          out_ctl
);
  localparam int LW = NW + 1;

  logic          gig;
  logic          ph_q;
  logic [NW-1:0] hold_nib_q;
  logic          hold_er_q;
  logic [LW-1:0] rise_d, fall_d, lane_q, rise_q, fall_pend;

  assign gig    = is_gig(speed);
  assign tx_rdy = gig || !ph_q;

  // lane encoding: {control bit, nibble}
  always_comb begin
    rise_d = '0;
    fall_d = '0;
    if (gig) begin
      if (tx_en) begin
        rise_d = {1'b1,  txd[NW-1:0]};
        fall_d = {tx_er, txd[2*NW-1:NW]};
      end
    end else if (ph_q) begin
      rise_d = {1'b1,      hold_nib_q};
      fall_d = {hold_er_q, hold_nib_q};
    end else if (tx_en) begin
      rise_d = {1'b1,  txd[NW-1:0]};
      fall_d = {tx_er, txd[NW-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= 1'b0;
      hold_nib_q <= '0;
      hold_er_q  <= 1'b0;
    end else if (gig || ph_q) begin
      ph_q <= 1'b0;
    end else if (tx_en) begin
      ph_q       <= 1'b1;
      hold_nib_q <= txd[2*NW-1:NW];
      hold_er_q  <= tx_er;
    end
  end

  gr_ddr_out #(.W(LW)) u_ddr (
    .clk      (clk),
    .rst_n    (rst_n),
    .d_rise   (rise_d),
    .d_fall   (fall_d),
    .q        (lane_q),
    .rise_q   (rise_q),
    .fall_pend(fall_pend)
  );

  assign out_nib = lane_q[NW-1:0];
  assign out_ctl = lane_q[NW];

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && tx_rdy) |=> (rise_q == '0 && fall_pend == '0));

  assert_gig_split_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gig && tx_en) |=> (rise_q[NW-1:0] == $past(txd[NW-1:0]) &&
                        fall_pend[NW-1:0] == $past(txd[2*NW-1:NW])));

  assert_ctl_split_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gig && tx_en) |=> (rise_q[NW] && fall_pend[NW] == $past(tx_er)));

  assert_nib_repeat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!gig && (tx_en || !tx_rdy)) |=> (rise_q[NW-1:0] == fall_pend[NW-1:0]));

  assert_rdy_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!gig && tx_en && tx_rdy) |=> (!tx_rdy || is_gig(speed)));
endmodule

// File: rtl/gr_rx_path.sv
`timescale 1ns/1ps
module gr_rx_path
  import gr_pkg::*;
#(
  parameter int NW = NIB_W
) (
  input  logic            rxc,
  input  logic            rst_n,
  input  logic [1:0]      speed,
  input  logic [NW-1:0]   in_nib,
  input  logic            in_ctl,
  output logic [2*NW-1:0] rxd,
  output logic            rx_dv,
  output logic            rx_er
);
  localparam int LW = NW + 1;

  logic          gig;
  logic [LW-1:0] r_lane, f_lane;
  logic          ph_q;
  logic [NW-1:0] lo_q;
  logic          lo_er_q;

  assign gig = is_gig(speed);

  gr_ddr_in #(.W(LW)) u_ddr (
    .clk   (rxc),
    .rst_n (rst_n),
    .d     ({in_ctl, in_nib}),
    .q_rise(r_lane),
    .q_fall(f_lane)
  );

  always_ff @(posedge rxc or negedge rst_n) begin
    if (!rst_n) begin
      rxd     <= '0;
      rx_dv   <= 1'b0;
      rx_er   <= 1'b0;
      ph_q    <= 1'b0;
      lo_q    <= '0;
      lo_er_q <= 1'b0;
    end else if (gig) begin
      rxd   <= {f_lane[NW-1:0], r_lane[NW-1:0]};
      rx_dv <= r_lane[NW];
      rx_er <= f_lane[NW];
      ph_q  <= 1'b0;
    end else begin
      rx_dv <= 1'b0;
      rx_er <= 1'b0;
      if (!r_lane[NW]) begin
        ph_q <= 1'b0;               // truncated byte: drop pending nibble
      end else if (!ph_q) begin
        lo_q    <= r_lane[NW-1:0];
        lo_er_q <= f_lane[NW];
        ph_q    <= 1'b1;
      end else begin
        rxd   <= {r_lane[NW-1:0], lo_q};
        rx_dv <= 1'b1;
        rx_er <= lo_er_q | f_lane[NW];
        ph_q  <= 1'b0;
      end
    end
  end

  assert_rx_dv_follow_R8: assert property (@(posedge rxc) disable iff (!rst_n)
    gig |=> (rx_dv == $past(r_lane[NW])));

  assert_rx_single_strobe_R9: assert property (@(posedge rxc) disable iff (!rst_n)
    (!gig && rx_dv) |=> !rx_dv);
endmodule

// File: rtl/gmii_rgmii_bridge.sv
`timescale 1ns/1ps
module gmii_rgmii_bridge
  import gr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        speed,
  input  logic [BYTE_W-1:0] gmii_txd,
  input  logic              gmii_tx_en,
  input  logic              gmii_tx_er,
  output logic              gmii_tx_rdy,
  output logic              rgmii_txc,
  output logic [NIB_W-1:0]  rgmii_txd,
  output logic              rgmii_tx_ctl,
  input  logic              rgmii_rxc,
  input  logic [NIB_W-1:0]  rgmii_rxd,
  input  logic              rgmii_rx_ctl,
  output logic [BYTE_W-1:0] gmii_rxd,
  output logic              gmii_rx_dv,
  output logic              gmii_rx_er
);
  assign rgmii_txc = clk;

  gr_tx_path #(.NW(NIB_W)) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .speed  (speed),
    .txd    (gmii_txd),
    .tx_en  (gmii_tx_en),
    .tx_er  (gmii_tx_er),
    .tx_rdy (gmii_tx_rdy),
    .out_nib(rgmii_txd),
    .out_ctl(rgmii_tx_ctl)
  );

  gr_rx_path #(.NW(NIB_W)) u_rx (
    .rxc   (rgmii_rxc),
    .rst_n (rst_n),
    .speed (speed),
    .in_nib(rgmii_rxd),
    .in_ctl(rgmii_rx_ctl),
    .rxd   (gmii_rxd),
    .rx_dv (gmii_rx_dv),
    .rx_er (gmii_rx_er)
  );
endmodule

// File: tb/gmii_rgmii_bridge_bench.sv
`timescale 1ns/1ps
module gmii_rgmii_bridge_bench;
  logic       clk = 1'b0;
  logic       rxc = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] speed = 2'b10;
  logic [7:0] txd = '0;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic       tx_rdy, txc_o, tx_ctl;
  logic [3:0] txn;
  logic [3:0] rxn = '0;
  logic       rx_ctl = 1'b0;
  logic [7:0] rxd;
  logic       rx_dv, rx_er;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always #4   rxc = ~rxc;

  gmii_rgmii_bridge u_gmii_rgmii_bridge (
    .clk(clk), .rst_n(rst_n), .speed(speed),
    .gmii_txd(txd), .gmii_tx_en(tx_en), .gmii_tx_er(tx_er), .gmii_tx_rdy(tx_rdy),
    .rgmii_txc(txc_o), .rgmii_txd(txn), .rgmii_tx_ctl(tx_ctl),
    .rgmii_rxc(rxc), .rgmii_rxd(rxn), .rgmii_rx_ctl(rx_ctl),
    .gmii_rxd(rxd), .gmii_rx_dv(rx_dv), .gmii_rx_er(rx_er)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    chk("R1 txd", {11'd0, tx_ctl, txn}, 16'h0);
    chk("R1 rx", {6'd0, rx_er, rx_dv, rxd}, 16'h0);
    chk("R1 rdy", {15'd0, tx_rdy}, 16'h1);
  endtask

  // gigabit: one byte, check both halves of the following cycle
  task automatic t_gig_tx(input logic [7:0] b, input logic er);
    @(posedge clk); #1;
    txd = b; tx_en = 1'b1; tx_er = er;
    @(posedge clk); #1;
    chk("R2 rise nibble", {12'd0, txn}, {12'd0, b[3:0]});
    chk("R3 rise ctl", {15'd0, tx_ctl}, 16'h1);
    chk("R5 rdy gig", {15'd0, tx_rdy}, 16'h1);
    @(negedge clk); #1;
    chk("R2 fall nibble", {12'd0, txn}, {12'd0, b[7:4]});
    chk("R3 fall ctl", {15'd0, tx_ctl}, {15'd0, er});
  endtask

  task automatic t_idle();
    @(posedge clk); #1;
    txd = 8'hA5; tx_en = 1'b0; tx_er = 1'b1;
    repeat (2) begin
      @(posedge clk); #1;
      chk("R4 idle high phase", {11'd0, tx_ctl, txn}, 16'h0);
      @(negedge clk); #1;
      chk("R4 idle low phase", {11'd0, tx_ctl, txn}, 16'h0);
    end
    tx_er = 1'b0;
  endtask

  // 10/100: two bytes offered back to back; the second waits out ready low
  task automatic t_nib_tx_pair(input logic [7:0] b0, input logic er0, input logic [7:0] b1);
    logic acc;
    @(posedge clk); #1;
    txd = b0; tx_en = 1'b1; tx_er = er0;
    do begin
      @(negedge clk); acc = tx_rdy;
      @(posedge clk);
    end while (!acc);
    #1;
    txd = b1; tx_er = 1'b0;
    chk("R6 lo rise", {11'd0, tx_ctl, txn}, {11'd0, 1'b1, b0[3:0]});
    @(negedge clk); #1;
    chk("R6 lo fall", {11'd0, tx_ctl, txn}, {11'd0, er0, b0[3:0]});
    chk("R7 rdy low", {15'd0, tx_rdy}, 16'h0);
    @(posedge clk); #1;
    chk("R7 hi rise held", {11'd0, tx_ctl, txn}, {11'd0, 1'b1, b0[7:4]});
    @(negedge clk); #1;
    chk("R6 hi fall", {11'd0, tx_ctl, txn}, {11'd0, er0, b0[7:4]});
    chk("R7 rdy back", {15'd0, tx_rdy}, 16'h1);
    @(posedge clk); #1;
    tx_en = 1'b0;
    chk("R7 second byte lo", {11'd0, tx_ctl, txn}, {11'd0, 1'b1, b1[3:0]});
    @(negedge clk); #1;
    chk("R6 second lo fall", {11'd0, tx_ctl, txn}, {11'd0, 1'b0, b1[3:0]});
    @(posedge clk); #1;
    chk("R6 second hi", {11'd0, tx_ctl, txn}, {11'd0, 1'b1, b1[7:4]});
    @(posedge clk); #1;
    chk("R4 idle after", {11'd0, tx_ctl, txn}, 16'h0);
  endtask

  // receive: rising half then falling half of one cycle
  task automatic rx_slot(input logic [3:0] rn, input logic rc, input logic [3:0] fn, input logic fc);
    @(negedge rxc); #1;
    rxn = rn; rx_ctl = rc;
    @(posedge rxc); #1;
    rxn = fn; rx_ctl = fc;
  endtask

  task automatic rx_idle(input int n);
    for (int i = 0; i < n; i++) rx_slot(4'h0, 1'b0, 4'h0, 1'b0);
  endtask

  task automatic t_gig_rx(input logic [7:0] b, input logic dv, input logic er);
    rx_slot(b[3:0], dv, b[7:4], er);
    @(posedge rxc); #1;
    chk("R8 rxd", {8'd0, rxd}, {8'd0, b});
    chk("R8 dv/er", {14'd0, rx_dv, rx_er}, {14'd0, dv, er});
    rx_idle(2);
  endtask

  task automatic t_nib_rx();
    rx_idle(3);
    rx_slot(4'h5, 1'b1, 4'h5, 1'b1);
    rx_slot(4'hA, 1'b1, 4'hA, 1'b0);
    @(posedge rxc); #1;
    chk("R9 byte", {8'd0, rxd}, 16'h00A5);
    chk("R9 dv/er", {14'd0, rx_dv, rx_er}, 16'h0003);
    @(posedge rxc); #1;
    chk("R9 one-cycle strobe", {15'd0, rx_dv}, 16'h0);
  endtask

  task automatic t_nib_realign();
    rx_idle(2);
    rx_slot(4'h1, 1'b1, 4'h1, 1'b0);
    rx_slot(4'h2, 1'b0, 4'h2, 1'b0);
    rx_slot(4'h3, 1'b1, 4'h3, 1'b0);
    chk("R10 no strobe on cut byte", {15'd0, rx_dv}, 16'h0);
    rx_slot(4'h4, 1'b1, 4'h4, 1'b0);
    chk("R10 no strobe mid byte", {15'd0, rx_dv}, 16'h0);
    @(posedge rxc); #1;
    chk("R10 realigned byte", {7'd0, rx_dv, rxd}, 16'h0143);
    rx_idle(2);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1 t_reset();
    t_gig_tx(8'h3C, 1'b0);
    t_gig_tx(8'hE7, 1'b1);
    speed = 2'b11;
    t_gig_tx(8'h96, 1'b0);
    speed = 2'b10;
    t_idle();
    t_gig_rx(8'h3C, 1'b1, 1'b0);
    t_gig_rx(8'hD2, 1'b1, 1'b1);
    t_gig_rx(8'h00, 1'b0, 1'b0);
    speed = 2'b01;
    t_idle();
    t_nib_tx_pair(8'h9B, 1'b1, 8'h47);
    t_nib_rx();
    t_nib_realign();
    speed = 2'b00;
    t_nib_tx_pair(8'h1F, 1'b0, 8'hC2);
    t_nib_rx();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule